// File: doc/BRIEF.md
# Delayed Core Clock Gate Controller

This block drives the enable input of an integrated clock-gating cell that sits on a core clock. It watches a status bit that says whether a processor clock is running. When that processor clock starts, the core clock enable rises after a programmable number of cycles. When the processor clock stops, the enable falls after a second, independent programmable number of cycles. All counting is done on a free-running always-on clock, so the controller keeps working while the core clock is gated.

A two-bit software override sits in front of the automatic path. While the override is active, the enable simply follows the override value. The delay tracker keeps following the processor clock status in the background, so releasing the override hands control straight back to an up-to-date automatic state. The gating cell itself is not part of this block.

Top module: `core_gate_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `core_ce` is 0 after that edge, and the automatic state returns to gated (0) with no delay in progress.
- R2: With `force_en` = 0, if `cpu_clk_on` becomes 1 and is first sampled at edge E while `core_ce` is 0, `core_ce` stays 0 through edge E+`ungate_dly`-1 and becomes 1 after edge E+`ungate_dly`, provided `cpu_clk_on` stays 1.
- R3: With `force_en` = 0, if `cpu_clk_on` becomes 0 and is first sampled at edge E while `core_ce` is 1, `core_ce` stays 1 through edge E+`gate_dly`-1 and becomes 0 after edge E+`gate_dly`, provided `cpu_clk_on` stays 0.
- R4: A delay value of 0 makes `core_ce` follow a change of `cpu_clk_on` after the very edge at which the change is first sampled.
- R5: If `cpu_clk_on` returns to the value of the automatic state before a delay completes, the pending change is abandoned: `core_ce` does not pulse, and a later change starts its delay count from zero.
- R6: While `force_en` is 1 at an edge, `core_ce` after that edge equals `force_val` sampled at that edge (1 = clock enabled, 0 = gated), regardless of `cpu_clk_on` and the delays.
- R7: The automatic state keeps tracking `cpu_clk_on` while the override is active; after `force_en` returns to 0, `core_ce` equals the automatic state from the next edge on.
- R8: The delay values are read live each cycle; if the active delay is lowered to or below the number of edges already counted, the change completes at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_clk_on | input | 1 | Processor clock running status (1 = running) |
| ungate_dly | input | DLY_W | Edges to wait after the processor clock starts |
| gate_dly | input | DLY_W | Edges to wait after the processor clock stops |
| force_en | input | 1 | Override enable |
| force_val | input | 1 | Override value for the gate enable |
| core_ce | output | 1 | Registered enable for the core clock gate |

## Verification
The assertions take for granted that `cpu_clk_on`, the delays and the override bits are already synchronous to `clk` and change only between edges; the bench drives every input on the falling edge, so each value is stable across the rising edge that samples it. They also assume the delay values may move at any time, which the random stimulus exercises by redrawing the delays mid-count, including below the elapsed count. Status toggles are drawn with a bias toward short runs so that abandoned delays occur often, alongside long holds that let every delay complete.

// File: rtl/core_gate_pkg.sv
package core_gate_pkg;
  localparam int DLY_W_DEF = 3;

  typedef enum logic {
    CE_GATED   = 1'b0,
    CE_RUNNING = 1'b1
  } ce_state_e;
endpackage

// File: rtl/core_gate_delay.sv
module core_gate_delay
  import core_gate_pkg::*;
#(
  parameter int DLY_W = DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_clk_on,
  input  logic [DLY_W-1:0] ungate_dly,
  input  logic [DLY_W-1:0] gate_dly,
  output ce_state_e        auto_q,
  output ce_state_e        auto_nxt
);
  localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

  ce_state_e        target;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_nxt;
  logic [DLY_W-1:0] limit;
  logic             pending;
  logic             done;

  always_comb begin
    target   = ce_state_e'(cpu_clk_on);
    pending  = (target != auto_q);
    limit    = (target == CE_RUNNING) ? ungate_dly : gate_dly;
    done     = pending && (cnt_q >= limit);
    auto_nxt = done ? target : auto_q;
    if (pending && !done) cnt_nxt = cnt_q + CNT_ONE;
    else                  cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_q <= CE_GATED;
      cnt_q  <= '0;
    end else begin
      auto_q <= auto_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (auto_q == CE_GATED) && (cnt_q == '0)); // R1

  AST_NO_EARLY_UNGATE: assert property (@(posedge clk) disable iff (rst)
    (auto_q == CE_GATED && cpu_clk_on && cnt_q < ungate_dly) |=> auto_q == CE_GATED); // R2

  AST_NO_EARLY_GATE: assert property (@(posedge clk) disable iff (rst)
    (auto_q == CE_RUNNING && !cpu_clk_on && cnt_q < gate_dly) |=> auto_q == CE_RUNNING); // R3

  AST_ZERO_DELAY_UNGATE: assert property (@(posedge clk) disable iff (rst)
    (auto_q == CE_GATED && cpu_clk_on && ungate_dly == '0) |=> auto_q == CE_RUNNING); // R4

  AST_ABANDON_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ce_state_e'(cpu_clk_on) == auto_q) |=> $stable(auto_q) && (cnt_q == '0)); // R5

  AST_LOWERED_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (auto_q == CE_RUNNING && !cpu_clk_on && cnt_q >= gate_dly) |=> auto_q == CE_GATED); // R8
endmodule

// File: rtl/core_gate_out.sv
module core_gate_out
  import core_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      force_en,
  input  logic      force_val,
  input  ce_state_e auto_nxt,
  input  ce_state_e auto_q,
  output logic      core_ce
);
  logic ce_nxt;

  always_comb begin
    ce_nxt = force_en ? force_val : (auto_nxt == CE_RUNNING);
  end

  always_ff @(posedge clk) begin
    if (rst) core_ce <= 1'b0;
    else     core_ce <= ce_nxt;
  end

  AST_RESET_GATED: assert property (@(posedge clk)
    rst |=> !core_ce); // R1

  AST_FORCE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    force_en |=> core_ce == $past(force_val)); // R6

  AST_AUTO_PASS: assert property (@(posedge clk) disable iff (rst)
    !force_en |=> core_ce == (auto_q == CE_RUNNING)); // R7
endmodule

// File: rtl/core_gate_ctrl.sv
module core_gate_ctrl
  import core_gate_pkg::*;
#(
  parameter int DLY_W = DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_clk_on,
  input  logic [DLY_W-1:0] ungate_dly,
  input  logic [DLY_W-1:0] gate_dly,
  input  logic             force_en,
  input  logic             force_val,
  output logic             core_ce
);
  ce_state_e auto_q;
  ce_state_e auto_nxt;

  core_gate_delay #(.DLY_W(DLY_W)) u_delay (
    .clk        (clk),
    .rst        (rst),
    .cpu_clk_on (cpu_clk_on),
    .ungate_dly (ungate_dly),
    .gate_dly   (gate_dly),
    .auto_q     (auto_q),
    .auto_nxt   (auto_nxt)
  );

  core_gate_out u_out (
    .clk       (clk),
    .rst       (rst),
    .force_en  (force_en),
    .force_val (force_val),
    .auto_nxt  (auto_nxt),
    .auto_q    (auto_q),
    .core_ce   (core_ce)
  );
endmodule

// File: tb/core_gate_ctrl_test.sv
`timescale 1ns/1ps
module core_gate_ctrl_test;
  localparam int DW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_clk_on = 1'b0;
  logic [DW-1:0] ungate_dly = '0;
  logic [DW-1:0] gate_dly = '0;
  logic          force_en = 1'b0;
  logic          force_val = 1'b0;
  logic          core_ce;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // bench reference state
  logic m_auto = 1'b0;
  int   m_cnt = 0;
  logic m_out = 1'b0;

  always #2.5 clk = ~clk;

  core_gate_ctrl #(.DLY_W(DW)) uut (
    .clk(clk), .rst(rst), .cpu_clk_on(cpu_clk_on), .ungate_dly(ungate_dly),
    .gate_dly(gate_dly), .force_en(force_en), .force_val(force_val), .core_ce(core_ce)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // expected behaviour of one rising edge, from the requirements
  function automatic logic ref_edge(input logic r, input logic req, input int sd,
                                    input int cd, input logic fe, input logic fv);
    int lim;
    if (r) begin
      m_auto = 1'b0; m_cnt = 0;
      return 1'b0;
    end
    if (req != m_auto) begin
      lim = req ? sd : cd;
      if (m_cnt >= lim) begin m_auto = req; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end else begin
      m_cnt = 0;
    end
    return fe ? fv : m_auto;
  endfunction

  task automatic check(input string tag, input logic exp);
    checks = checks + 1;
    if (core_ce !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: core_ce=%b expected=%b at cycle %0d", tag, core_ce, exp, cycles);
    end
  endtask

  // inputs are stable at the rising edge; sample on the following falling edge
  task automatic step(input string tag);
    @(posedge clk);
    m_out = ref_edge(rst, cpu_clk_on, int'(ungate_dly), int'(gate_dly), force_en, force_val);
    @(negedge clk);
    check(tag, m_out);
  endtask

  task automatic drive(input logic req, input int sd, input int cd,
                       input logic fe, input logic fv);
    cpu_clk_on = req; ungate_dly = DW'(sd); gate_dly = DW'(cd);
    force_en = fe; force_val = fv;
  endtask

  initial begin
    void'($urandom(1234));
    @(negedge clk);
    drive(1'b1, 0, 0, 1'b1, 1'b1);
    step("R1 reset");
    step("R1 reset");
    rst = 1'b0;

    // R2: ungate delay 3, explicit edge counting
    drive(1'b1, 3, 5, 1'b0, 1'b0);
    step("R2 edge0"); check("R2 still gated", 1'b0);
    step("R2 edge1"); step("R2 edge2"); check("R2 before limit", 1'b0);
    step("R2 edge3"); check("R2 enabled at limit", 1'b1);

    // R3: gate delay 5
    drive(1'b0, 3, 5, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin step("R3 counting"); check("R3 still running", 1'b1); end
    step("R3 limit"); check("R3 gated at limit", 1'b0);

    // R4: zero delays
    drive(1'b1, 0, 0, 1'b0, 1'b0);
    step("R4 zero ungate"); check("R4 next edge on", 1'b1);
    drive(1'b0, 0, 0, 1'b0, 1'b0);
    step("R4 zero gate"); check("R4 next edge off", 1'b0);

    // R5: abandoned request, then restart from zero
    drive(1'b1, 4, 4, 1'b0, 1'b0);
    step("R5 start"); step("R5 count");
    drive(1'b0, 4, 4, 1'b0, 1'b0);
    step("R5 abandon"); check("R5 no pulse", 1'b0);
    drive(1'b1, 4, 4, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin step("R5 recount"); check("R5 restart from zero", 1'b0); end
    step("R5 done"); check("R5 completes", 1'b1);

    // R8: lower gate delay below elapsed count
    drive(1'b0, 0, 7, 1'b0, 1'b0);
    step("R8 c0"); step("R8 c1"); step("R8 c2");
    drive(1'b0, 0, 1, 1'b0, 1'b0);
    step("R8 lowered"); check("R8 completes next edge", 1'b0);

    // R6 and R7: force on while automatic tracks a start, then release
    drive(1'b0, 2, 2, 1'b1, 1'b1);
    step("R6 force on"); check("R6 forced high", 1'b1);
    drive(1'b1, 2, 2, 1'b1, 1'b0);
    step("R6 force off"); check("R6 forced low", 1'b0);
    step("R7 tracking"); step("R7 tracking");
    drive(1'b1, 2, 2, 1'b0, 1'b0);
    step("R7 release"); check("R7 auto already running", 1'b1);

    // constrained random phase
    for (int n = 0; n < 20000; n++) begin
      logic req, fe, fv;
      int sd, cd;
      req = ($urandom_range(0, 3) == 0) ? ~cpu_clk_on : cpu_clk_on;
      if ($urandom_range(0, 15) == 0) begin sd = $urandom_range(0, 7); cd = $urandom_range(0, 7); end
      else begin sd = int'(ungate_dly); cd = int'(gate_dly); end
      fe = ($urandom_range(0, 7) == 0);
      fv = $urandom_range(0, 1);
      drive(req, sd, cd, fe, fv);
      if (fe) step("R6 random force");
      else if (req) step("R2 random ungate path");
      else step("R3 random gate path");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule